// File: doc/BRIEF.md
# Correlation Result Host Readout Port

This block hands complex correlation results to an external processor that reads them over a shared 16-bit asynchronous data bus. A result is a 32-bit real part and a 32-bit imaginary part. It arrives on a valid/ready input and is split into four 16-bit holding words. A ready flag then tells the processor that a result is waiting.

The processor selects the block with an active-high chip select, asserts a read strobe and picks a word with two address bits. The addressed word appears on the bus for as long as chip select and the address are held. The read strobe is combined with chip select and then brought into the block clock domain. Each falling edge of that combined strobe counts as one completed read. After the fourth completed read the ready flag drops and the holding words are free for the next result.

On the result input, `res_ready` is high exactly while no result is waiting. The producer is never stalled. A `res_valid` pulse taken while `res_ready` is low is dropped, and a sticky overrun flag is set, so a result that is partly read is never overwritten. When chip select is low the bus output is high-impedance and other devices may drive it.

Top module: `corr_readout_port`

## Requirements
- R1: After reset `data_ready` and `overrun` are 0, `res_ready` is 1, and every holding word reads 0x0000.
- R2: While `host_cs` is 0 the block does not drive `host_data`, so another device's value on the shared bus reads back unchanged.
- R3: While `host_cs` is 1, `host_data` shows the word chosen by `host_addr`: 0 gives real[31:16], 1 gives real[15:0], 2 gives imag[31:16] and 3 gives imag[15:0].
- R4: A cycle with `res_valid` and `res_ready` both high captures both parts, and `data_ready` is 1 at the following clock edge.
- R5: `data_ready` stays 1 through three completed reads. It drops to 0 within five clock cycles after the strobe of the fourth completed read is deasserted.
- R6: Reads of the same address each count as a completed read.
- R7: A read strobe while `host_cs` is 0 is not counted.
- R8: A `res_valid` pulse while `data_ready` is 1 is dropped: the holding words keep the earlier result and `overrun` becomes 1 at the next edge.
- R9: `res_ready` equals the inverse of `data_ready` at all times.
- R10: Once `overrun` is 1 it stays 1 until reset, even through later captures and reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_valid | input | 1 | A new result is offered |
| res_ready | output | 1 | The holding words are free |
| res_re | input | 32 | Real part of the offered result |
| res_im | input | 32 | Imaginary part of the offered result |
| host_cs | input | 1 | Host chip select, active high |
| host_rd | input | 1 | Host read strobe, active high |
| host_addr | input | 2 | Holding word select |
| host_data | output | 16 | Shared bus, high-impedance when not selected |
| data_ready | output | 1 | A result is waiting to be read |
| overrun | output | 1 | Sticky: a result was dropped |

## Verification
The read counter is not visible at the ports, so a counter that is off by one appears as `data_ready` falling one read too early or too late. This is seen within five cycles after the deciding strobe ends. A holding word that is overwritten or decoded wrongly shows on the bus during the very next selected read. A lost or stuck ready state shows up as `res_ready` disagreeing with the expected capture at the next clock edge. A bus driver that is not released shows up as a corrupted value from the other device in the same cycle that chip select drops.

// File: rtl/corr_rd_pkg.sv
package corr_rd_pkg;
  localparam int DEF_DATA_W = 32;
  localparam int DEF_BUS_W  = 16;
  localparam int DEF_SYNC   = 2;

  // Tracker phase, held in a single register
  typedef enum logic {
    PH_EMPTY = 1'b0,
    PH_FULL  = 1'b1
  } hold_phase_e;
endpackage

// File: rtl/crp_strobe_sync.sv
module crp_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_in,
  output logic done_pulse
);
  logic [STAGES-1:0] chain;
  logic              prev;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= strobe_in;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev <= 1'b0;
    else        prev <= chain[STAGES-1];

  assign done_pulse = prev & ~chain[STAGES-1];
endmodule

// File: rtl/crp_hold_bank.sv
module crp_hold_bank #(
  parameter int DATA_W = 32,
  parameter int BUS_W  = 16,
  localparam int PARTS  = DATA_W / BUS_W,
  localparam int NWORDS = 2 * PARTS,
  localparam int ADDR_W = $clog2(NWORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] re,
  input  logic [DATA_W-1:0] im,
  input  logic [ADDR_W-1:0] addr,
  output logic [BUS_W-1:0]  word
);
  logic [BUS_W-1:0] words [NWORDS];

  generate
    for (genvar i = 0; i < NWORDS; i++) begin : g_word
      logic [BUS_W-1:0] src;
      if (i < PARTS) begin : g_re
        assign src = re[(PARTS-1-i)*BUS_W +: BUS_W];
      end else begin : g_im
        assign src = im[(NWORDS-1-i)*BUS_W +: BUS_W];
      end
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)    words[i] <= '0;
        else if (load) words[i] <= src;
    end
  endgenerate

  assign word = words[addr];
endmodule

// File: rtl/crp_read_tracker.sv
module crp_read_tracker
  import corr_rd_pkg::*;
#(
  parameter int NWORDS = 4,
  localparam int CNT_W = $clog2(NWORDS)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic offer,
  input  logic read_done,
  output logic full,
  output logic load,
  output logic dropped
);
  hold_phase_e      phase;
  logic [CNT_W-1:0] cnt;
  logic             ovr;

  assign full    = (phase == PH_FULL);
  assign load    = offer & ~full;
  assign dropped = ovr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_EMPTY;
      cnt   <= '0;
      ovr   <= 1'b0;
    end else begin
      if (offer && full) ovr <= 1'b1;
      if (load) begin
        phase <= PH_FULL;
        cnt   <= '0;
      end else if (full && read_done) begin
        if (cnt == CNT_W'(NWORDS-1)) begin
          phase <= PH_EMPTY;
          cnt   <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/corr_readout_port.sv
module corr_readout_port
  import corr_rd_pkg::*;
#(
  parameter int DATA_W = DEF_DATA_W,
  parameter int BUS_W  = DEF_BUS_W,
  parameter int SYNC   = DEF_SYNC,
  localparam int NWORDS = 2 * (DATA_W / BUS_W),
  localparam int ADDR_W = $clog2(NWORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_valid,
  output logic              res_ready,
  input  logic [DATA_W-1:0] res_re,
  input  logic [DATA_W-1:0] res_im,
  input  logic              host_cs,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] host_addr,
  output logic [BUS_W-1:0]  host_data,
  output logic              data_ready,
  output logic              overrun
);
  logic             read_done;
  logic             load;
  logic [BUS_W-1:0] word;

  crp_strobe_sync #(.STAGES(SYNC)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .strobe_in(host_cs & host_rd),
    .done_pulse(read_done)
  );

  crp_read_tracker #(.NWORDS(NWORDS)) u_track (
    .clk(clk), .rst_n(rst_n),
    .offer(res_valid), .read_done(read_done),
    .full(data_ready), .load(load), .dropped(overrun)
  );

  crp_hold_bank #(.DATA_W(DATA_W), .BUS_W(BUS_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .load(load),
    .re(res_re), .im(res_im), .addr(host_addr), .word(word)
  );

  assign res_ready = ~data_ready;
  assign host_data = host_cs ? word : {BUS_W{1'bz}};
endmodule

// File: rtl/corr_readout_port_chk.sv
module corr_readout_port_chk #(
  parameter int ADDR_W = 2,
  parameter int BUS_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              res_valid,
  input logic              res_ready,
  input logic              host_cs,
  input logic [ADDR_W-1:0] host_addr,
  input logic [BUS_W-1:0]  host_data,
  input logic              data_ready,
  input logic              overrun
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |-> (!data_ready && !overrun));

  assert_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready) |=> data_ready);

  assert_drop_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && data_ready) |=> overrun);

  // R3 / R8: a waiting result is held steady on the bus
  assert_hold_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_cs && data_ready && $past(host_cs && data_ready) && $stable(host_addr))
      |-> $stable(host_data));

  assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
endmodule

bind corr_readout_port corr_readout_port_chk #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_ready(res_ready),
  .host_cs(host_cs), .host_addr(host_addr), .host_data(host_data),
  .data_ready(data_ready), .overrun(overrun)
);

// File: tb/corr_readout_port_bench.sv
module corr_readout_port_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        res_valid = 1'b0;
  logic        res_ready;
  logic [31:0] res_re = '0, res_im = '0;
  logic        host_cs = 1'b0, host_rd = 1'b0;
  logic [1:0]  host_addr = '0;
  wire  [15:0] bus;
  logic        data_ready, overrun;
  logic        other_en = 1'b0;
  int          n_run = 0, n_fail = 0;
  logic [15:0] exp_q [$];

  always #10 clk = ~clk;
  assign bus = other_en ? 16'hA5C3 : 16'hzzzz;

  corr_readout_port u_corr_readout_port (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_ready(res_ready),
    .res_re(res_re), .res_im(res_im), .host_cs(host_cs), .host_rd(host_rd),
    .host_addr(host_addr), .host_data(bus), .data_ready(data_ready),
    .overrun(overrun)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: offers a result and pushes the expected words if it will be taken
  task automatic push_result(input logic [31:0] re, input logic [31:0] im);
    bit taken;
    @(negedge clk);
    taken = res_ready;
    res_re = re; res_im = im; res_valid = 1'b1;
    @(negedge clk);
    res_valid = 1'b0;
    if (taken) begin
      exp_q.push_back(re[31:16]); exp_q.push_back(re[15:0]);
      exp_q.push_back(im[31:16]); exp_q.push_back(im[15:0]);
      chk(data_ready == 1'b1, "R4 ready after capture", 32'(data_ready), 1);
    end
  endtask

  // one host read; returns the word seen on the bus
  task automatic host_read(input logic [1:0] a, input bit cs, output logic [15:0] w);
    @(negedge clk);
    host_cs = cs; host_addr = a; host_rd = 1'b1;
    @(negedge clk);
    #1 w = bus;
    host_rd = 1'b0;
    @(negedge clk);
    host_cs = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  // monitor: pops the expected words and compares four in-order reads
  task automatic read_all(input string tag);
    logic [15:0] w;
    for (int k = 0; k < 4; k++) begin
      host_read(2'(k), 1'b1, w);
      if (exp_q.size() != 0) begin
        logic [15:0] e;
        e = exp_q.pop_front();
        chk(w == e, tag, 32'(w), 32'(e));
      end
      if (k < 3) chk(data_ready == 1'b1, "R5 ready held before fourth read", 32'(data_ready), 1);
    end
    chk(data_ready == 1'b0, "R5 ready cleared after fourth read", 32'(data_ready), 0);
    chk(res_ready == 1'b1, "R9 res_ready after clear", 32'(res_ready), 1);
  endtask

  initial begin
    logic [15:0] w;
    fork
      begin
        repeat (20000) @(posedge clk);
        n_fail++; n_run++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    join_none

    repeat (3) @(negedge clk);
    chk(!data_ready && !overrun && res_ready, "R1 reset flags",
        {29'd0, data_ready, overrun, res_ready}, 1);
    rst_n = 1'b1;
    @(negedge clk);
    host_read(2'd2, 1'b1, w);
    chk(w == 16'h0000, "R1 word zero after reset", 32'(w), 0);

    // R2: shared bus left free
    other_en = 1'b1; #1;
    chk(bus == 16'hA5C3, "R2 bus released", 32'(bus), 32'hA5C3);
    other_en = 1'b0;

    // R3 / R4 / R5: basic result, in-order reads
    push_result(32'h1234_5678, 32'h9ABC_DEF0);
    chk(res_ready == 1'b0, "R9 res_ready low while full", 32'(res_ready), 0);
    read_all("R3 address map");

    // R3 with a second pattern
    push_result(32'hFFFF_0001, 32'h8000_7FFF);
    read_all("R3 second pattern");

    // R6: same address four times
    push_result(32'hCAFE_BEEF, 32'h0BAD_F00D);
    for (int k = 0; k < 4; k++) begin
      host_read(2'd1, 1'b1, w);
      chk(w == 16'hBEEF, "R6 repeated address", 32'(w), 32'hBEEF);
      if (k < 3) chk(data_ready, "R6 ready held", 32'(data_ready), 1);
    end
    chk(!data_ready, "R6 four repeats clear ready", 32'(data_ready), 0);
    exp_q.delete();

    // R7: strobe without chip select is not counted
    push_result(32'h0102_0304, 32'h0506_0708);
    exp_q.delete();
    for (int k = 0; k < 3; k++) host_read(2'(k), 1'b1, w);
    host_read(2'd3, 1'b0, w);
    chk(data_ready, "R7 unselected strobe ignored", 32'(data_ready), 1);
    host_read(2'd3, 1'b1, w);
    chk(w == 16'h0708, "R7 last word", 32'(w), 32'h0708);
    chk(!data_ready, "R7 fourth real read clears", 32'(data_ready), 0);

    // R8: result while full is dropped
    push_result(32'hAAAA_BBBB, 32'hCCCC_DDDD);
    chk(!overrun, "R8 no overrun yet", 32'(overrun), 0);
    push_result(32'h1111_2222, 32'h3333_4444);
    chk(overrun, "R8 overrun set", 32'(overrun), 1);
    read_all("R8 earlier result kept");

    // R10: overrun sticky through later traffic
    push_result(32'h5555_6666, 32'h7777_8888);
    read_all("R10 traffic after overrun");
    chk(overrun, "R10 overrun sticky", 32'(overrun), 1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule